// File: doc/BRIEF.md
# Flash Read Address Feedback Monitor

This block sits between a multi-port bus front end and a flash read array. It confirms that each lookup used the row the controller meant to select. When a port issues a read, the block keeps the expected word address in a per-port register. The array returns data along with two sideband signals: the word address it actually decoded and a decode-error flag. The block compares these with the stored address. If they disagree, the port's fault interface gives a one-cycle report carrying the expected address. The port's read buffer is invalidated, and the bus transfer ends with an error.

The block also covers two other events. While the array runs an integrity sequence, any new request is aborted with an error response and never reaches the array. When returned data carries a non-correctable error, the data is replaced with a fixed illegal-opcode constant. Bit 2 of the requested address picks one of two constants, and the event itself is not reported.

Each port runs a two-state machine. `PS_IDLE` accepts a request. The transition IDLE→WAIT (issue) happens when a request arrives while the array is free. The transition IDLE→IDLE (abort) happens when a request arrives while the array is busy. `PS_WAIT` holds the expected address until a return arrives. The transition WAIT→IDLE (land) happens on the return and produces the response, the fault report and the buffer update.

Top module: `fbm_top`

## Requirements
- R1: After reset every port has req_ready=1, rsp_valid=0, rsp_err=0, flt_valid=0 and buf_valid=0.
- R2: A request accepted while arr_busy=0 drives arr_rd_req high in the same cycle, with arr_rd_word equal to address bits [ADDR_W-1:2]. The port then leaves IDLE and holds req_ready=0 until its return arrives.
- R3: A return whose word equals the expected word, with bad=0 and ue=0, gives rsp_valid=1, rsp_err=0 and rsp_data equal to the array data on the next cycle. It also sets buf_valid=1 with buf_tag equal to the expected word.
- R4: A return whose word differs from the expected word in any bit gives, on the next cycle, rsp_valid=1, rsp_err=1, rsp_data=0 and buf_valid=0. It also gives a flt_valid pulse of exactly one cycle with flt_addr equal to the expected word.
- R5: A return with the decode-error flag set counts as a fault even when the word matches, with the same outputs as R4.
- R6: A fault on one port raises only that port's flt_valid and leaves the other port's buffer unchanged.
- R7: A request arriving while arr_busy=1 issues no array read. It gives rsp_valid=1 and rsp_err=1 with no fault on the next cycle, leaves buf_valid unchanged and keeps the port in IDLE.
- R8: A return with ue=1 and no fault gives rsp_err=0 and no fault, and leaves the buffer unchanged. rsp_data is OPC_ALIGN0 when address bit 2 is 0 and OPC_ALIGN1 when it is 1.
- R9: A return with ue=1 that is also a fault is handled as a fault: R4 applies and no opcode is substituted.
- R10: In WAIT the port produces no response for as long as no return arrives. A return arriving while the port is in IDLE is ignored: no response, no fault and no buffer change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | NPORT | Read request per port |
| req_addr | input | NPORT*ADDR_W | Byte address per port |
| req_ready | output | NPORT | Port is idle and can accept a request |
| arr_busy | input | 1 | Array integrity sequence in progress |
| arr_rd_req | output | NPORT | Read issued to the array |
| arr_rd_word | output | NPORT*(ADDR_W-2) | Word address issued to the array |
| arr_ret_valid | input | NPORT | Array return strobe |
| arr_ret_data | input | NPORT*DATA_W | Returned read data |
| arr_ret_word | input | NPORT*(ADDR_W-2) | Word address the array actually decoded |
| arr_ret_bad | input | NPORT | Array decode-error flag |
| arr_ret_ue | input | NPORT | Non-correctable data error |
| rsp_valid | output | NPORT | Bus response strobe |
| rsp_err | output | NPORT | Bus response error |
| rsp_data | output | NPORT*DATA_W | Bus response data |
| buf_valid | output | NPORT | Read buffer valid |
| buf_tag | output | NPORT*(ADDR_W-2) | Word address held by the read buffer |
| flt_valid | output | NPORT | Fault report pulse, one interface per port |
| flt_addr | output | NPORT*(ADDR_W-2) | Expected word address of the faulting read |

## Verification
The bench builds the block with two ports, 24-bit byte addresses (22-bit words) and 32-bit data. It overrides the two opcode constants with distinct values, so every substituted word can be told apart from real data and from each other. A 22-bit word lets the bench flip the lowest and the highest compared bit and confirm that both are caught. Two ports make it possible to show fault isolation and simultaneous returns on both ports.

// File: rtl/fbm_pkg.sv
`timescale 1ns/1ps
package fbm_pkg;
    typedef enum logic [0:0] {
        PS_IDLE = 1'b0,
        PS_WAIT = 1'b1
    } port_state_e;
endpackage

// File: rtl/fbm_word_cmp.sv
`timescale 1ns/1ps
module fbm_word_cmp #(
    parameter int WORD_W = 22
) (
    input  logic [WORD_W-1:0] exp_word,
    input  logic [WORD_W-1:0] got_word,
    input  logic              got_bad,
    output logic              fault
);
    logic [WORD_W-1:0] diff;

    always_comb begin
        diff  = exp_word ^ got_word;
        fault = got_bad | (|diff);
    end
endmodule

// File: rtl/fbm_opcode_sel.sv
`timescale 1ns/1ps
module fbm_opcode_sel #(
    parameter int               DATA_W      = 32,
    parameter logic [DATA_W-1:0] OPC_ALIGN0 = '0,
    parameter logic [DATA_W-1:0] OPC_ALIGN1 = '1
) (
    input  logic              half_sel,
    output logic [DATA_W-1:0] opcode
);
    always_comb begin
        opcode = half_sel ? OPC_ALIGN1 : OPC_ALIGN0;
    end
endmodule

// File: rtl/fbm_port.sv
`timescale 1ns/1ps
module fbm_port
    import fbm_pkg::*;
#(
    parameter int                WORD_W     = 22,
    parameter int                DATA_W     = 32,
    parameter logic [DATA_W-1:0] OPC_ALIGN0 = '0,
    parameter logic [DATA_W-1:0] OPC_ALIGN1 = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [WORD_W-1:0] req_word,
    output logic              req_ready,
    input  logic              arr_busy,
    output logic              rd_req,
    output logic [WORD_W-1:0] rd_word,
    input  logic              ret_valid,
    input  logic [DATA_W-1:0] ret_data,
    input  logic [WORD_W-1:0] ret_word,
    input  logic              ret_bad,
    input  logic              ret_ue,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_data,
    output logic              buf_valid,
    output logic [WORD_W-1:0] buf_tag,
    output logic              flt_valid,
    output logic [WORD_W-1:0] flt_addr
);
    port_state_e       state, state_nx;
    logic [WORD_W-1:0] exp_word;
    logic              accept, issue, abort, land;
    logic              fault;
    logic [DATA_W-1:0] opcode;

    assign accept    = req_valid && (state == PS_IDLE);
    assign issue     = accept && !arr_busy;
    assign abort     = accept && arr_busy;
    assign land      = (state == PS_WAIT) && ret_valid;
    assign req_ready = (state == PS_IDLE);
    assign rd_req    = issue;
    assign rd_word   = req_word;

    fbm_word_cmp #(.WORD_W(WORD_W)) cmp_i (
        .exp_word (exp_word),
        .got_word (ret_word),
        .got_bad  (ret_bad),
        .fault    (fault)
    );

    fbm_opcode_sel #(
        .DATA_W     (DATA_W),
        .OPC_ALIGN0 (OPC_ALIGN0),
        .OPC_ALIGN1 (OPC_ALIGN1)
    ) opc_i (
        .half_sel (exp_word[0]),
        .opcode   (opcode)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            PS_IDLE: if (issue) state_nx = PS_WAIT;
            PS_WAIT: if (ret_valid) state_nx = PS_IDLE;
            default: state_nx = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PS_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     exp_word <= '0;
        else if (issue) exp_word <= req_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_data  <= '0;
            buf_valid <= 1'b0;
            buf_tag   <= '0;
            flt_valid <= 1'b0;
            flt_addr  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            flt_valid <= 1'b0;
            if (abort) begin
                rsp_valid <= 1'b1;
                rsp_err   <= 1'b1;
                rsp_data  <= '0;
            end else if (land) begin
                rsp_valid <= 1'b1;
                if (fault) begin
                    rsp_err   <= 1'b1;
                    rsp_data  <= '0;
                    flt_valid <= 1'b1;
                    flt_addr  <= exp_word;
                    buf_valid <= 1'b0;
                end else if (ret_ue) begin
                    rsp_data  <= opcode;
                end else begin
                    rsp_data  <= ret_data;
                    buf_valid <= 1'b1;
                    buf_tag   <= exp_word;
                end
            end
        end
    end

    // R4
    flt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |=> !flt_valid);

    // R4
    flt_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |-> (!buf_valid && rsp_valid && rsp_err));

    // R2
    issue_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> (state == PS_WAIT && !req_ready));

    // R7
    abort_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && arr_busy) |=> (rsp_valid && rsp_err && !flt_valid && $stable(buf_valid)));

    // R8
    ue_subst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (land && ret_ue && !fault) |=> (!flt_valid && !rsp_err && rsp_data == opcode));

    // R10
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_WAIT && !ret_valid) |=> (state == PS_WAIT && !rsp_valid));
endmodule

// File: rtl/fbm_top.sv
`timescale 1ns/1ps
module fbm_top #(
    parameter int                 NPORT      = 2,
    parameter int                 ADDR_W     = 24,
    parameter int                 DATA_W     = 32,
    parameter logic [DATA_W-1:0]  OPC_ALIGN0 = 32'h0000_0000,
    parameter logic [DATA_W-1:0]  OPC_ALIGN1 = 32'hFFFF_FFFF
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NPORT-1:0]                req_valid,
    input  logic [NPORT*ADDR_W-1:0]         req_addr,
    output logic [NPORT-1:0]                req_ready,
    input  logic                            arr_busy,
    output logic [NPORT-1:0]                arr_rd_req,
    output logic [NPORT*(ADDR_W-2)-1:0]     arr_rd_word,
    input  logic [NPORT-1:0]                arr_ret_valid,
    input  logic [NPORT*DATA_W-1:0]         arr_ret_data,
    input  logic [NPORT*(ADDR_W-2)-1:0]     arr_ret_word,
    input  logic [NPORT-1:0]                arr_ret_bad,
    input  logic [NPORT-1:0]                arr_ret_ue,
    output logic [NPORT-1:0]                rsp_valid,
    output logic [NPORT-1:0]                rsp_err,
    output logic [NPORT*DATA_W-1:0]         rsp_data,
    output logic [NPORT-1:0]                buf_valid,
    output logic [NPORT*(ADDR_W-2)-1:0]     buf_tag,
    output logic [NPORT-1:0]                flt_valid,
    output logic [NPORT*(ADDR_W-2)-1:0]     flt_addr
);
    localparam int WORD_W = ADDR_W - 2;

    logic [NPORT*2-1:0] byte_bits_unused;

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        assign byte_bits_unused[g*2 +: 2] = req_addr[g*ADDR_W +: 2];

        fbm_port #(
            .WORD_W     (WORD_W),
            .DATA_W     (DATA_W),
            .OPC_ALIGN0 (OPC_ALIGN0),
            .OPC_ALIGN1 (OPC_ALIGN1)
        ) port_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .req_valid (req_valid[g]),
            .req_word  (req_addr[g*ADDR_W+2 +: WORD_W]),
            .req_ready (req_ready[g]),
            .arr_busy  (arr_busy),
            .rd_req    (arr_rd_req[g]),
            .rd_word   (arr_rd_word[g*WORD_W +: WORD_W]),
            .ret_valid (arr_ret_valid[g]),
            .ret_data  (arr_ret_data[g*DATA_W +: DATA_W]),
            .ret_word  (arr_ret_word[g*WORD_W +: WORD_W]),
            .ret_bad   (arr_ret_bad[g]),
            .ret_ue    (arr_ret_ue[g]),
            .rsp_valid (rsp_valid[g]),
            .rsp_err   (rsp_err[g]),
            .rsp_data  (rsp_data[g*DATA_W +: DATA_W]),
            .buf_valid (buf_valid[g]),
            .buf_tag   (buf_tag[g*WORD_W +: WORD_W]),
            .flt_valid (flt_valid[g]),
            .flt_addr  (flt_addr[g*WORD_W +: WORD_W])
        );
    end

    // R6
    flt_port_sep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(flt_valid) <= $countones(rsp_err));

    wire unused_ok = &{1'b0, byte_bits_unused};
endmodule

// File: tb/fbm_top_tb_top.sv
`timescale 1ns/1ps
module fbm_top_tb_top;
    localparam int NP = 2;
    localparam int AW = 24;
    localparam int DW = 32;
    localparam int WW = AW - 2;
    localparam logic [DW-1:0] OPC0 = 32'h0BAD_C0DE;
    localparam logic [DW-1:0] OPC1 = 32'h0000_DEAD;

    typedef struct packed {
        logic          p;
        logic [AW-1:0] addr;
        logic [WW-1:0] flip;
        logic          bad;
        logic          ue;
        logic          busy;
        logic [DW-1:0] data;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 24'h00_1230, 22'h0,        1'b0, 1'b0, 1'b0, 32'h1111_0001},
        '{1'b1, 24'h7F_FFFC, 22'h0,        1'b0, 1'b0, 1'b0, 32'h2222_0002},
        '{1'b0, 24'h00_1234, 22'h00_0001,  1'b0, 1'b0, 1'b0, 32'h3333_0003},
        '{1'b1, 24'hA5_5A54, 22'h20_0000,  1'b0, 1'b0, 1'b0, 32'h4444_0004},
        '{1'b0, 24'h00_0104, 22'h0,        1'b1, 1'b0, 1'b0, 32'h5555_0005},
        '{1'b1, 24'h12_3004, 22'h0,        1'b0, 1'b1, 1'b0, 32'h6666_0006},
        '{1'b0, 24'h00_2000, 22'h0,        1'b0, 1'b1, 1'b0, 32'h7777_0007},
        '{1'b1, 24'h00_4444, 22'h0,        1'b0, 1'b0, 1'b1, 32'h8888_0008},
        '{1'b0, 24'h33_3338, 22'h00_0400,  1'b0, 1'b1, 1'b0, 32'h9999_0009},
        '{1'b0, 24'h00_0040, 22'h0,        1'b0, 1'b0, 1'b0, 32'hAAAA_000A}
    };

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NP-1:0]        req_valid = '0;
    logic [NP*AW-1:0]     req_addr = '0;
    logic [NP-1:0]        req_ready;
    logic                 arr_busy = 1'b0;
    logic [NP-1:0]        arr_rd_req;
    logic [NP*WW-1:0]     arr_rd_word;
    logic [NP-1:0]        arr_ret_valid = '0;
    logic [NP*DW-1:0]     arr_ret_data = '0;
    logic [NP*WW-1:0]     arr_ret_word = '0;
    logic [NP-1:0]        arr_ret_bad = '0;
    logic [NP-1:0]        arr_ret_ue = '0;
    logic [NP-1:0]        rsp_valid, rsp_err, buf_valid, flt_valid;
    logic [NP*DW-1:0]     rsp_data;
    logic [NP*WW-1:0]     buf_tag, flt_addr;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    logic          bv [NP];
    logic [WW-1:0] btag [NP];

    fbm_top #(
        .NPORT(NP), .ADDR_W(AW), .DATA_W(DW), .OPC_ALIGN0(OPC0), .OPC_ALIGN1(OPC1)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .arr_busy(arr_busy), .arr_rd_req(arr_rd_req),
        .arr_rd_word(arr_rd_word), .arr_ret_valid(arr_ret_valid),
        .arr_ret_data(arr_ret_data), .arr_ret_word(arr_ret_word),
        .arr_ret_bad(arr_ret_bad), .arr_ret_ue(arr_ret_ue), .rsp_valid(rsp_valid),
        .rsp_err(rsp_err), .rsp_data(rsp_data), .buf_valid(buf_valid),
        .buf_tag(buf_tag), .flt_valid(flt_valid), .flt_addr(flt_addr)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run = n_run + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_bufs();
        for (int q = 0; q < NP; q++) begin
            chk("R6 buf_valid", 64'(buf_valid[q]), 64'(bv[q]));
            if (bv[q]) chk("R3 buf_tag", 64'(buf_tag[q*WW +: WW]), 64'(btag[q]));
        end
    endtask

    task automatic issue(input int p, input logic [AW-1:0] a);
        req_valid[p] = 1'b1;
        req_addr[p*AW +: AW] = a;
        #1;
        chk("R2 arr_rd_req", 64'(arr_rd_req[p]), 64'd1);
        chk("R2 arr_rd_word", 64'(arr_rd_word[p*WW +: WW]), 64'(a[AW-1:2]));
        @(negedge clk);
        req_valid[p] = 1'b0;
        chk("R2 req_ready low", 64'(req_ready[p]), 64'd0);
    endtask

    task automatic ret_set(input int p, input logic [WW-1:0] w, input logic bad,
                           input logic ue, input logic [DW-1:0] d);
        arr_ret_valid[p] = 1'b1;
        arr_ret_word[p*WW +: WW] = w;
        arr_ret_bad[p] = bad;
        arr_ret_ue[p] = ue;
        arr_ret_data[p*DW +: DW] = d;
    endtask

    task automatic expect_land(input int p, input logic [AW-1:0] a, input logic flt,
                               input logic ue, input logic [DW-1:0] d);
        logic [WW-1:0] ew;
        logic [DW-1:0] ed;
        ew = a[AW-1:2];
        if (flt) ed = '0;
        else if (ue) ed = a[2] ? OPC1 : OPC0;
        else ed = d;
        chk("R3 rsp_valid", 64'(rsp_valid[p]), 64'd1);
        chk(flt ? "R4 rsp_err" : "R8 rsp_err", 64'(rsp_err[p]), 64'(flt));
        chk(ue && !flt ? "R8 rsp_data" : "R3 rsp_data", 64'(rsp_data[p*DW +: DW]), 64'(ed));
        chk(flt ? "R5 flt_valid" : "R9 flt_valid", 64'(flt_valid[p]), 64'(flt));
        if (flt) chk("R4 flt_addr", 64'(flt_addr[p*WW +: WW]), 64'(ew));
        if (flt) bv[p] = 1'b0;
        else if (!ue) begin bv[p] = 1'b1; btag[p] = ew; end
    endtask

    initial begin
        for (int q = 0; q < NP; q++) begin bv[q] = 1'b0; btag[q] = '0; end
        repeat (3) @(negedge clk);
        chk("R1 req_ready", 64'(req_ready), 64'(2'b11));
        chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R1 rsp_err", 64'(rsp_err), 64'd0);
        chk("R1 flt_valid", 64'(flt_valid), 64'd0);
        chk("R1 buf_valid", 64'(buf_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            automatic vec_t v = VECS[i];
            automatic int p = int'(v.p);
            automatic int o = 1 - p;
            if (v.busy) begin
                arr_busy = 1'b1;
                req_valid[p] = 1'b1;
                req_addr[p*AW +: AW] = v.addr;
                #1;
                chk("R7 no arr_rd_req", 64'(arr_rd_req[p]), 64'd0);
                @(negedge clk);
                req_valid[p] = 1'b0;
                arr_busy = 1'b0;
                chk("R7 rsp_valid", 64'(rsp_valid[p]), 64'd1);
                chk("R7 rsp_err", 64'(rsp_err[p]), 64'd1);
                chk("R7 flt_valid", 64'(flt_valid[p]), 64'd0);
                chk("R7 req_ready", 64'(req_ready[p]), 64'd1);
            end else begin
                automatic logic flt = (v.flip != '0) || v.bad;
                issue(p, v.addr);
                ret_set(p, v.addr[AW-1:2] ^ v.flip, v.bad, v.ue, v.data);
                @(negedge clk);
                arr_ret_valid = '0;
                expect_land(p, v.addr, flt, v.ue, v.data);
            end
            chk("R6 other flt_valid", 64'(flt_valid[o]), 64'd0);
            check_bufs();
            @(negedge clk);
            chk("R4 flt one cycle", 64'(flt_valid), 64'd0);
        end

        // R10: WAIT holds with no return
        issue(1, 24'h05_0008);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R10 no rsp while waiting", 64'(rsp_valid[1]), 64'd0);
            chk("R10 ready stays low", 64'(req_ready[1]), 64'd0);
        end
        ret_set(1, 22'(24'h05_0008 >> 2), 1'b0, 1'b0, 32'hBEEF_0001);
        @(negedge clk);
        arr_ret_valid = '0;
        expect_land(1, 24'h05_0008, 1'b0, 1'b0, 32'hBEEF_0001);
        check_bufs();
        @(negedge clk);

        // R10: stray return on idle port 0 is ignored
        ret_set(0, 22'h3F_FFFF, 1'b1, 1'b0, 32'hDEAD_BEEF);
        @(negedge clk);
        arr_ret_valid = '0;
        chk("R10 stray rsp_valid", 64'(rsp_valid[0]), 64'd0);
        chk("R10 stray flt_valid", 64'(flt_valid[0]), 64'd0);
        check_bufs();

        // R6: simultaneous returns, fault on port 0, good on port 1
        req_valid = 2'b11;
        req_addr[0 +: AW] = 24'h01_0010;
        req_addr[AW +: AW] = 24'h02_0020;
        @(negedge clk);
        req_valid = '0;
        ret_set(0, 22'(24'h01_0010 >> 2) ^ 22'h00_0100, 1'b0, 1'b0, 32'h0101_0101);
        ret_set(1, 22'(24'h02_0020 >> 2), 1'b0, 1'b0, 32'h0202_0202);
        @(negedge clk);
        arr_ret_valid = '0;
        expect_land(0, 24'h01_0010, 1'b1, 1'b0, 32'h0101_0101);
        expect_land(1, 24'h02_0020, 1'b0, 1'b0, 32'h0202_0202);
        chk("R6 only port0 faults", 64'(flt_valid), 64'(2'b01));
        check_bufs();
        @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule